// File: doc/BRIEF.md
# Per-Interface Timeslot Allocator

This block keeps track of which timeslots are in use on each output interface of a circuit switch. For every interface it holds a bit vector with one bit per timeslot. A bit at 0 marks the slot free, and a bit at 1 marks it taken.

An allocate request names an interface. The block reads that interface's vector into a scratch register and passes it through a priority decoder. The decoder picks the free slot with the highest bit position. The block then sets that bit and writes the vector back to the table.

A deallocate request names an interface and a slot, and the block clears that one bit. Each request is a read cycle followed by a write-back cycle. The block does not accept new requests until the write-back is done.

Top module: `slot_alloc`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `full_o` and `err_o` are low, and every timeslot of every interface is free.
- R2: An allocate returns on `slot_o` the free timeslot with the highest number. Back-to-back allocates on one interface therefore return 15, 14, 13 and so on downward.
- R3: A request is taken on a rising edge where `busy_o` is low. `busy_o` is then high for exactly two cycles. `done_o` is high for one cycle, starting at the edge two cycles after the request was taken, and at that same edge `busy_o` falls.
- R4: A request presented while `busy_o` is high is ignored and leaves the table unchanged.
- R5: During an allocate, the value on `slot_i` has no effect on the result.
- R6: Each interface's vector is separate, so operations on one interface do not change the slots of any other interface.
- R7: An allocate on an interface with all slots used completes with `done_o` and `full_o` high, and leaves the vector unchanged.
- R8: A deallocate of a used slot clears its bit, so a later allocate can return that slot. It completes with `done_o` high and `err_o` low.
- R9: A deallocate of a slot that is already free completes with `err_o` high and leaves the table unchanged.
- R10: When `alloc_i` and `dealloc_i` are both high on the edge where a request is taken, only the allocate is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Allocate request |
| dealloc_i | input | 1 | Deallocate request |
| intf_i | input | 4 | Interface number |
| slot_i | input | 4 | Timeslot to free (not used for allocate) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slot_o | output | 4 | Allocated (or freed) timeslot number |
| full_o | output | 1 | The allocate found no free slot |
| err_o | output | 1 | The deallocate targeted a slot that was already free |

## Verification
The first test allocates one interface until it is full. This shows that the decoder walks downward from slot 15, and it exposes the exhausted case along with any off-by-one in the bit update.

Other tests send requests on fresh interfaces while a different one is full. They also raise `slot_i` during an allocate and send new requests while the block is busy. These show that each interface is kept separate and that ignored inputs change nothing.

A free, a double free and a re-allocate follow. They separate a correct clear from a wrong bit position and from a double free that modifies the table. A final test raises both request inputs together, which shows which operation wins.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int unsigned NUM_IF = 16;
  localparam int unsigned NUM_TS = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } slot_state_e;
endpackage

// File: rtl/slot_prio_enc.sv
module slot_prio_enc #(
  parameter int unsigned NUM_TS = 16,
  localparam int unsigned TS_W = $clog2(NUM_TS)
) (
  input  logic [NUM_TS-1:0] used_i,
  output logic [TS_W-1:0]   slot_o,
  output logic              found_o
);
  // Ascending scan: the last hit (the highest free bit) wins.
  always_comb begin
    slot_o  = '0;
    found_o = 1'b0;
    for (int i = 0; i < int'(NUM_TS); i++) begin
      if (!used_i[i]) begin
        slot_o  = TS_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int unsigned NUM_IF = 16,
  parameter int unsigned NUM_TS = 16,
  localparam int unsigned IF_W = $clog2(NUM_IF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IF_W-1:0]   rd_if_i,
  output logic [NUM_TS-1:0] rd_vec_o,
  input  logic              we_i,
  input  logic [IF_W-1:0]   wr_if_i,
  input  logic [NUM_TS-1:0] wr_vec_i
);
  logic [NUM_TS-1:0] vec_q [NUM_IF];

  for (genvar g = 0; g < int'(NUM_IF); g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   vec_q[g] <= '0;
      else if (we_i && (wr_if_i == IF_W'(g)))        vec_q[g] <= wr_vec_i;
    end
  end

  assign rd_vec_o = vec_q[rd_if_i];
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
#(
  parameter int unsigned NUM_IF = 16,
  parameter int unsigned NUM_TS = 16,
  localparam int unsigned IF_W = $clog2(NUM_IF),
  localparam int unsigned TS_W = $clog2(NUM_TS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              dealloc_i,
  input  logic [IF_W-1:0]   intf_i,
  input  logic [TS_W-1:0]   slot_i,
  // table side
  output logic [IF_W-1:0]   tbl_if_o,
  input  logic [NUM_TS-1:0] tbl_vec_i,
  output logic              tbl_we_o,
  output logic [NUM_TS-1:0] tbl_vec_o,
  // decoder side
  output logic [NUM_TS-1:0] dec_vec_o,
  input  logic [TS_W-1:0]   dec_slot_i,
  input  logic              dec_found_i,
  // results
  output logic              busy_o,
  output logic              done_o,
  output logic [TS_W-1:0]   slot_o,
  output logic              full_o,
  output logic              err_o
);
  slot_state_e       state_q;
  logic              is_alloc_q;
  logic [IF_W-1:0]   if_q;
  logic [TS_W-1:0]   ts_q;
  logic [NUM_TS-1:0] scratch_q;
  logic              start;

  assign start = (state_q == ST_IDLE) && (alloc_i || dealloc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_alloc_q <= 1'b0;
      if_q       <= '0;
      ts_q       <= '0;
      scratch_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_RD;
          is_alloc_q <= alloc_i;   // allocate wins a tie
          if_q       <= intf_i;
          ts_q       <= slot_i;
        end
        ST_RD: begin
          scratch_q <= tbl_vec_i;
          state_q   <= ST_WR;
        end
        ST_WR:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tbl_if_o  = if_q;
  assign dec_vec_o = scratch_q;

  always_comb begin
    tbl_vec_o = scratch_q;
    tbl_we_o  = 1'b0;
    if (state_q == ST_WR) begin
      if (is_alloc_q) begin
        if (dec_found_i) begin
          tbl_vec_o[dec_slot_i] = 1'b1;
          tbl_we_o = 1'b1;
        end
      end else if (scratch_q[ts_q]) begin
        tbl_vec_o[ts_q] = 1'b0;
        tbl_we_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      slot_o <= '0;
      full_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= (state_q == ST_WR);
      if (state_q == ST_WR) begin
        slot_o <= is_alloc_q ? dec_slot_i : ts_q;
        full_o <= is_alloc_q && !dec_found_i;
        err_o  <= !is_alloc_q && !scratch_q[ts_q];
      end else begin
        full_o <= 1'b0;
        err_o  <= 1'b0;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int unsigned NUM_IF = slot_pkg::NUM_IF,
  parameter int unsigned NUM_TS = slot_pkg::NUM_TS,
  localparam int unsigned IF_W = $clog2(NUM_IF),
  localparam int unsigned TS_W = $clog2(NUM_TS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_i,
  input  logic            dealloc_i,
  input  logic [IF_W-1:0] intf_i,
  input  logic [TS_W-1:0] slot_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [TS_W-1:0] slot_o,
  output logic            full_o,
  output logic            err_o
);
  logic [IF_W-1:0]   tbl_if;
  logic [NUM_TS-1:0] tbl_rd, tbl_wr, dec_vec;
  logic              tbl_we, dec_found;
  logic [TS_W-1:0]   dec_slot;

  slot_table #(.NUM_IF(NUM_IF), .NUM_TS(NUM_TS)) u_table (
    .clk_i, .rst_ni,
    .rd_if_i(tbl_if), .rd_vec_o(tbl_rd),
    .we_i(tbl_we), .wr_if_i(tbl_if), .wr_vec_i(tbl_wr)
  );

  slot_prio_enc #(.NUM_TS(NUM_TS)) u_prio (
    .used_i(dec_vec), .slot_o(dec_slot), .found_o(dec_found)
  );

  slot_ctrl #(.NUM_IF(NUM_IF), .NUM_TS(NUM_TS)) u_ctrl (
    .clk_i, .rst_ni, .alloc_i, .dealloc_i, .intf_i, .slot_i,
    .tbl_if_o(tbl_if), .tbl_vec_i(tbl_rd), .tbl_we_o(tbl_we), .tbl_vec_o(tbl_wr),
    .dec_vec_o(dec_vec), .dec_slot_i(dec_slot), .dec_found_i(dec_found),
    .busy_o, .done_o, .slot_o, .full_o, .err_o
  );
endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
  parameter int unsigned TS_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic [TS_W-1:0] slot_o,
  input logic            full_o,
  input logic            err_o
);
  assert_done_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_two_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  assert_fall_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && err_o));
  assert_flag_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o || err_o) |-> done_o);
  assert_slot_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(busy_o)) |-> $stable(slot_o));
endmodule

bind slot_alloc slot_alloc_chk #(.TS_W(TS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .slot_o(slot_o), .full_o(full_o), .err_o(err_o)
);

// File: tb/tb_slot_alloc.sv
`timescale 1ns/1ps
module tb_slot_alloc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alloc_i = 1'b0, dealloc_i = 1'b0;
  logic [3:0] intf_i = '0, slot_i = '0;
  logic       busy_o, done_o, full_o, err_o;
  logic [3:0] slot_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  slot_alloc dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One operation; checks R3 timing and returns the result fields.
  task automatic op(input bit a, input bit d, input int itf, input int ts,
                    output int slot, output bit full, output bit err);
    @(negedge clk_i);
    alloc_i = a; dealloc_i = d; intf_i = 4'(itf); slot_i = 4'(ts);
    @(negedge clk_i);
    alloc_i = 0; dealloc_i = 0;
    chk("R3 busy after accept", busy_o, 1);
    @(negedge clk_i);
    chk("R3 busy second cycle", busy_o, 1);
    chk("R3 no early done", done_o, 0);
    @(negedge clk_i);
    chk("R3 done pulse", done_o, 1);
    chk("R3 busy drops", busy_o, 0);
    slot = slot_o; full = full_o; err = err_o;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 full", full_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_fill();
    int s; bit f, e;
    for (int k = 0; k < 16; k++) begin
      op(1, 0, 5, 0, s, f, e);
      chk("R2 descending slot", s, 15 - k);
      chk("R2 not full", f, 0);
    end
    op(1, 0, 5, 0, s, f, e);
    chk("R7 full flag", f, 1);
    op(1, 0, 5, 0, s, f, e);
    chk("R7 still full, table unchanged", f, 1);
  endtask

  task automatic t_independent();
    int s; bit f, e;
    op(1, 0, 6, 0, s, f, e);
    chk("R6 other interface fresh", s, 15);
    chk("R6 not full", f, 0);
  endtask

  task automatic t_slot_ignored();
    int s; bit f, e;
    op(1, 0, 2, 3, s, f, e);
    chk("R5 slot_i ignored", s, 15);
  endtask

  task automatic t_busy_ignored();
    int s; bit f, e;
    @(negedge clk_i);
    alloc_i = 1; intf_i = 4'd9;
    @(negedge clk_i);
    intf_i = 4'd10;                    // held while busy
    @(negedge clk_i);
    @(negedge clk_i);
    alloc_i = 0;
    chk("R3 done for first", done_o, 1);
    @(negedge clk_i);
    op(1, 0, 10, 0, s, f, e);
    chk("R4 busy request dropped", s, 15);
  endtask

  task automatic t_free();
    int s; bit f, e;
    op(0, 1, 5, 7, s, f, e);
    chk("R8 no error", e, 0);
    chk("R8 slot echo", s, 7);
    op(0, 1, 5, 7, s, f, e);
    chk("R9 double free flagged", e, 1);
    op(1, 0, 5, 0, s, f, e);
    chk("R8 freed slot reused", s, 7);
    op(1, 0, 5, 0, s, f, e);
    chk("R9 table unchanged by double free", f, 1);
    op(0, 1, 11, 4, s, f, e);
    chk("R9 free on fresh interface", e, 1);
  endtask

  task automatic t_both();
    int s; bit f, e;
    op(1, 1, 5, 3, s, f, e);
    chk("R10 allocate wins", f, 1);
    chk("R10 no dealloc error", e, 0);
    op(0, 1, 5, 3, s, f, e);
    chk("R10 slot 3 still used", e, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_fill();
    t_independent();
    t_slot_ignored();
    t_busy_ignored();
    t_free();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule